// File: doc/BRIEF.md
# Dual ADC Sample Packer

This block sits between two 14-bit ADC channels and a 32-bit-wide capture FIFO. It takes one sample from each channel on every clock. Each sample is sign-extended to a 16-bit lane, and accepted samples are packed into 32-bit words. A word leaves with a one-cycle valid strobe.

A 2-bit pack mode chooses the word layout:
- **Two-channel layout:** one sample of each channel goes into every word.
- **Single-channel layout:** two consecutive samples of one channel go into a word.

Capture is gated by a trigger. The trigger comes either from a software-driven control bit or from an external pin, and its polarity can be inverted. The external pin first passes through a small synchronizer.

Capture opens on a low-to-high transition of the polarity-corrected trigger and stays open while that trigger is high. When the trigger drops, or when the mode changes in the middle of a pair, a half-built word is thrown away.

Top module: `adc_pair_packer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `word_valid` is 0 and `word_out` is all zeros.
- R2: With `trig_sel` = 1 the trigger is taken from `trig_ext` through a 2-stage synchronizer whose stages reset to 0. An edge on `trig_ext` therefore acts two cycles later than the same edge on `trig_reg`. With `trig_sel` = 0 the trigger is `trig_reg`, and `trig_ext` has no effect.
- R3: With `trig_invert` = 1 the corrected trigger is the complement of the selected source, so samples are captured while the source is low. With `trig_invert` = 0 the source is used as is.
- R4: Capture starts only after the corrected trigger has been seen low at least once since reset. A trigger that is already high when reset ends captures nothing until it has dropped and risen again.
- R5: A sample presented while the corrected trigger is low is not captured and produces no word. Any half-filled word is discarded at that point.
- R6: With `pack_mode` 2'b00 or 2'b11, each captured cycle yields, one clock later, a word whose bits 15:0 hold channel A and bits 31:16 hold channel B, with `word_valid` high for that one cycle.
- R7: With `pack_mode` 2'b01, captured channel-A samples are paired in arrival order. The earlier sample goes in bits 15:0 and the later one in bits 31:16, so a word appears one clock after every second captured sample.
- R8: With `pack_mode` 2'b10, channel B is paired exactly as channel A is in R7.
- R9: Every 14-bit sample is treated as two's complement. It fills bits 13:0 of its 16-bit lane, and bits 15:14 repeat sample bit 13.
- R10: If `pack_mode` differs from the mode of a pending half word, that half word is discarded. The sample that arrives with the new mode then starts a fresh word under the new mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_a | input | 14 | Channel A sample, two's complement |
| chan_b | input | 14 | Channel B sample, two's complement |
| pack_mode | input | 2 | 00/11 both channels, 01 channel A pairs, 10 channel B pairs |
| trig_sel | input | 1 | 0 selects the control bit, 1 selects the external pin |
| trig_invert | input | 1 | 1 inverts the selected trigger |
| trig_reg | input | 1 | Software-driven trigger bit |
| trig_ext | input | 1 | External trigger pin |
| word_out | output | 32 | Packed word |
| word_valid | output | 1 | One-cycle strobe marking a new packed word |

## Verification
The assertions assume that samples, mode and trigger controls are stable around the rising clock edge. They also treat the external pin as a level that the synchronizer delays by a fixed count, not as a truly asynchronous signal. The stimulus respects both assumptions by changing every input only on the falling edge. The trigger, select, invert and mode inputs are switched only between runs of whole cycles, so the cadence and layout checks see clean, repeatable windows.

// File: rtl/adc_pack_pkg.sv
package adc_pack_pkg;

  localparam logic [1:0] MODE_PAIR_LO = 2'b00;
  localparam logic [1:0] MODE_ONLY_A  = 2'b01;
  localparam logic [1:0] MODE_ONLY_B  = 2'b10;
  localparam logic [1:0] MODE_PAIR_HI = 2'b11;

  // True when the mode packs two consecutive samples of one channel.
  function automatic logic mode_is_single(input logic [1:0] m);
    return (m == MODE_ONLY_A) || (m == MODE_ONLY_B);
  endfunction

endpackage

// File: rtl/adc_lane_sext.sv
module adc_lane_sext #(
  parameter int IN_W  = 14,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  smp,
  output logic [OUT_W-1:0] lane
);

  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    if (i < IN_W) begin : g_copy
      assign lane[i] = smp[i];
    end else begin : g_sign
      assign lane[i] = smp[IN_W-1];
    end
  end

endmodule

// File: rtl/adc_trig_gate.sv
module adc_trig_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic src_sel,
  input  logic invert,
  input  logic trig_sw,
  input  logic trig_pin,
  output logic accept
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   seen_low_q;
  logic                   corr_trig;

  // The external pin is resynchronised; every stage resets low.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
    end else begin
      for (int i = SYNC_STAGES - 1; i > 0; i--) begin
        sync_q[i] <= sync_q[i-1];
      end
      sync_q[0] <= trig_pin;
    end
  end

  always_comb begin
    corr_trig = (src_sel ? sync_q[SYNC_STAGES-1] : trig_sw) ^ invert;
  end

  // Sticky flag: the corrected trigger has been low since reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      seen_low_q <= 1'b0;
    end else if (!corr_trig) begin
      seen_low_q <= 1'b1;
    end
  end

  assign accept = corr_trig & seen_low_q;

endmodule

// File: rtl/adc_word_packer.sv
module adc_word_packer
  import adc_pack_pkg::*;
#(
  parameter int LANE_W = 16,
  localparam int WORD_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [1:0]        mode,
  input  logic [LANE_W-1:0] lane_a,
  input  logic [LANE_W-1:0] lane_b,
  output logic [WORD_W-1:0] word,
  output logic              valid
);

  logic              have_half_q;
  logic [LANE_W-1:0] half_q;
  logic [1:0]        half_mode_q;
  logic              single;
  logic              restart;
  logic [LANE_W-1:0] pick;

  always_comb begin
    single  = mode_is_single(mode);
    pick    = (mode == MODE_ONLY_A) ? lane_a : lane_b;
    restart = !have_half_q || (mode != half_mode_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_half_q <= 1'b0;
      half_q      <= '0;
      half_mode_q <= MODE_PAIR_LO;
      word        <= '0;
      valid       <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (!accept) begin
        have_half_q <= 1'b0;
      end else if (restart) begin
        if (!single) begin
          word        <= {lane_b, lane_a};
          valid       <= 1'b1;
          have_half_q <= 1'b0;
        end else begin
          half_q      <= pick;
          half_mode_q <= mode;
          have_half_q <= 1'b1;
        end
      end else begin
        word        <= {pick, half_q};
        valid       <= 1'b1;
        have_half_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/adc_pair_packer.sv
module adc_pair_packer #(
  parameter int SMP_W       = 14,
  parameter int LANE_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W     = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SMP_W-1:0]  chan_a,
  input  logic [SMP_W-1:0]  chan_b,
  input  logic [1:0]        pack_mode,
  input  logic              trig_sel,
  input  logic              trig_invert,
  input  logic              trig_reg,
  input  logic              trig_ext,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid
);

  logic              accept;
  logic [LANE_W-1:0] lane_a;
  logic [LANE_W-1:0] lane_b;

  adc_trig_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .src_sel  (trig_sel),
    .invert   (trig_invert),
    .trig_sw  (trig_reg),
    .trig_pin (trig_ext),
    .accept   (accept)
  );

  adc_lane_sext #(.IN_W(SMP_W), .OUT_W(LANE_W)) u_sext_a (
    .smp  (chan_a),
    .lane (lane_a)
  );

  adc_lane_sext #(.IN_W(SMP_W), .OUT_W(LANE_W)) u_sext_b (
    .smp  (chan_b),
    .lane (lane_b)
  );

  adc_word_packer #(.LANE_W(LANE_W)) u_pack (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .mode   (pack_mode),
    .lane_a (lane_a),
    .lane_b (lane_b),
    .word   (word_out),
    .valid  (word_valid)
  );

endmodule

// File: rtl/adc_pair_packer_chk.sv
module adc_pair_packer_chk
  import adc_pack_pkg::*;
#(
  parameter int SMP_W  = 14,
  parameter int LANE_W = 16,
  localparam int WORD_W = 2 * LANE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              accept,
  input logic [SMP_W-1:0]  chan_a,
  input logic [1:0]        pack_mode,
  input logic              trig_sel,
  input logic              trig_invert,
  input logic              trig_reg,
  input logic [WORD_W-1:0] word_out,
  input logic              word_valid
);

  logic [LANE_W-1:0]       a_wide;
  logic [LANE_W-SMP_W:0]   lo_top;
  logic [LANE_W-SMP_W:0]   hi_top;

  assign a_wide = {{(LANE_W-SMP_W){chan_a[SMP_W-1]}}, chan_a};
  assign lo_top = word_out[LANE_W-1:SMP_W-1];
  assign hi_top = word_out[WORD_W-1:LANE_W+SMP_W-1];

  // R5: a cycle without capture produces no word
  assert_no_word_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !word_valid);

  // R6: two-channel capture yields a word next cycle with channel A low
  assert_pair_low_lane_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && !mode_is_single(pack_mode)) |=>
      (word_valid && word_out[LANE_W-1:0] == $past(a_wide)));

  // R9: both lanes carry a proper sign extension
  assert_lane_sign_R9: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> ((&lo_top || ~|lo_top) && (&hi_top || ~|hi_top)));

  // R3: corrected control-bit trigger low means no word next cycle
  assert_polarity_block_R3: assert property (@(posedge clk) disable iff (rst)
    (!trig_sel && (trig_reg == trig_invert)) |=> !word_valid);

  // R7: single-channel words never come on back-to-back cycles
  assert_single_cadence_R7: assert property (@(posedge clk) disable iff (rst)
    (word_valid && mode_is_single($past(pack_mode))) |-> !$past(word_valid));

endmodule

bind adc_pair_packer adc_pair_packer_chk #(.SMP_W(SMP_W), .LANE_W(LANE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .accept      (accept),
  .chan_a      (chan_a),
  .pack_mode   (pack_mode),
  .trig_sel    (trig_sel),
  .trig_invert (trig_invert),
  .trig_reg    (trig_reg),
  .word_out    (word_out),
  .word_valid  (word_valid)
);

// File: tb/sim_adc_pair_packer.sv
`timescale 1ns/1ps
module sim_adc_pair_packer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] chan_a = '0;
  logic [13:0] chan_b = '0;
  logic [1:0]  pack_mode = 2'b00;
  logic        trig_sel = 1'b0;
  logic        trig_invert = 1'b0;
  logic        trig_reg = 1'b0;
  logic        trig_ext = 1'b0;
  logic [31:0] word_out;
  logic        word_valid;

  int    checks = 0;
  int    bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  bit          m_h0, m_h1, m_seen, m_half_v, m_valid;
  logic [15:0] m_half;
  logic [1:0]  m_hmode;
  logic [31:0] m_word;

  always #2.5 clk = ~clk;

  adc_pair_packer u0 (
    .clk(clk), .rst(rst), .chan_a(chan_a), .chan_b(chan_b),
    .pack_mode(pack_mode), .trig_sel(trig_sel), .trig_invert(trig_invert),
    .trig_reg(trig_reg), .trig_ext(trig_ext),
    .word_out(word_out), .word_valid(word_valid)
  );

  function automatic logic [15:0] widen(input logic [13:0] s);
    int v;
    v = (s >= 14'h2000) ? int'(s) - 16384 : int'(s);
    return 16'(v);
  endfunction

  task automatic model_step();
    bit eff, acc, single;
    logic [15:0] pick;
    if (rst) begin
      m_h0 = 0; m_h1 = 0; m_seen = 0; m_half_v = 0; m_valid = 0;
      m_half = '0; m_hmode = 2'b00; m_word = '0;
      return;
    end
    eff = (trig_sel ? m_h1 : trig_reg) ^ trig_invert;
    m_h1 = m_h0;
    m_h0 = trig_ext;
    acc = eff && m_seen;
    if (!eff) m_seen = 1;
    m_valid = 0;
    single = (pack_mode == 2'b01) || (pack_mode == 2'b10);
    pick = (pack_mode == 2'b01) ? widen(chan_a) : widen(chan_b);
    if (!acc) begin
      m_half_v = 0;
    end else if (!m_half_v || pack_mode != m_hmode) begin
      if (!single) begin
        m_word = {widen(chan_b), widen(chan_a)};
        m_valid = 1;
        m_half_v = 0;
      end else begin
        m_half = pick;
        m_hmode = pack_mode;
        m_half_v = 1;
      end
    end else begin
      m_word = {pick, m_half};
      m_valid = 1;
      m_half_v = 0;
    end
  endtask

  task automatic compare();
    checks++;
    if (word_valid !== m_valid || word_out !== m_word) begin
      bad++;
      $display("FAIL %s valid=%0b expected %0b word=%h expected %h",
               cur_req, word_valid, m_valid, word_out, m_word);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      chan_a = 14'($urandom);
      chan_b = 14'($urandom);
      cycle();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog expired in %s actual=hung expected=finished", cur_req);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state, with the control-bit trigger already high for R4
    cur_req = "R1";
    trig_reg = 1'b1;
    repeat (3) cycle();
    rst = 1'b0;
    cur_req = "R4";
    run(5);
    trig_reg = 1'b0; run(2);
    trig_reg = 1'b1;
    cur_req = "R6"; run(6);
    pack_mode = 2'b11; run(4);
    cur_req = "R7"; pack_mode = 2'b01; run(9);
    // R9: sign boundaries on both single-channel layouts
    cur_req = "R9";
    trig_reg = 1'b0; run(1); trig_reg = 1'b1;
    chan_a = 14'h2000; cycle();
    chan_a = 14'h1FFF; cycle();
    pack_mode = 2'b10;
    chan_b = 14'h3FFF; cycle();
    chan_b = 14'h0001; cycle();
    cur_req = "R8"; run(8);
    cur_req = "R5"; pack_mode = 2'b01; run(3);
    trig_reg = 1'b0; run(3);
    trig_reg = 1'b1; run(4);
    cur_req = "R10";
    trig_reg = 1'b0; run(1); trig_reg = 1'b1;
    run(1);
    pack_mode = 2'b10; run(3);
    pack_mode = 2'b00; run(2);
    cur_req = "R3";
    trig_invert = 1'b1; trig_reg = 1'b0; run(4);
    trig_reg = 1'b1; run(3);
    trig_reg = 1'b0; run(4);
    cur_req = "R2";
    trig_invert = 1'b0; trig_sel = 1'b1; trig_ext = 1'b0; trig_reg = 1'b1;
    run(4);
    trig_ext = 1'b1; run(6);
    trig_ext = 1'b0; trig_reg = 1'b0; run(4);
    trig_reg = 1'b1; run(3);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule